// File: doc/BRIEF.md
# Transmit Host Input Stage with Strap-Selected FIFO or Bypass

This block is the host-facing front end of a serial link transmitter. A host presents 10-bit characters on a parallel bus, qualified by an enable pin. The block passes them to a downstream line encoder at the character rate of the reference clock. When no character is ready, the block raises a fill request so that the encoder inserts an idle character.

Four static strap inputs, held constant after reset, set the operating mode:

- **FIFO mode.** Host writes are clocked by a separate transmit clock. Characters pass through a 16-entry dual-clock FIFO. The FIFO uses Gray-coded pointers with two-flop synchronizers, and it reports full, empty and half-full.
- **Bypass mode.** The transmit clock is ignored. The host drives characters directly in the reference-clock domain. The full pin can be turned into a pacing strobe at half the reference rate, which marks the cycles in which a character is taken.
- **External-FIFO strap.** When set, the enable pin is treated as the empty flag of an attached FIFO. This flips the enable to active high and moves data capture one edge later. It also changes the polarity of the full and empty flags.

Top module: `tx_host_if`

## Requirements
- R1: While `rst_ni` is low, and directly after it is released, the block is in its reset state. Full and half-full are inactive, empty is asserted, `enc_valid_o` is 0 and `fill_req_o` is 1. The pin levels follow R2 and R3.
- R2: With `ext_fifo_i`=0, full, empty and half-full are all active low. After the FIFO drains, `empty_o`=0, `full_o`=1 and `half_o`=1.
- R3: With `ext_fifo_i`=1, `full_o` and `empty_o` are active high and `half_o` stays active low.
- R4: With `ext_fifo_i`=0, `tx_en_i` is active low. Data on `tx_data_i` is captured on the same clock edge at which the enable is sampled active.
- R5: With `ext_fifo_i`=1, `tx_en_i` is active high. Data is captured on the edge after the one at which the enable was sampled active.
- R6: With `bypass_ni`=1 (FIFO mode), writes are clocked by `tx_clk_i`. Characters reach `enc_data_o` with `enc_valid_o`=1 in write order, one per `ref_clk_i` cycle while the FIFO is not empty.
- R7: The FIFO holds 16 characters. A write made while full is asserted at the write edge is ignored, and the stored contents are unchanged.
- R8: Half-full is asserted while the write-side occupancy is 8 or more, so it is always asserted while full is asserted.
- R9: When the FIFO is empty, the next `ref_clk_i` cycle has `enc_valid_o`=0 and `fill_req_o`=1. `fill_req_o` is always the inverse of `enc_valid_o`.
- R10: With `bypass_ni`=0, `tx_clk_i` is unused. A character captured on a `ref_clk_i` edge appears on `enc_data_o` with `enc_valid_o`=1 right after that same edge.
- R11: In bypass mode with `pre_sel_i`=1 or `rate_hi_i`=0, full toggles on every `ref_clk_i` edge. It is inactive right after reset. A character is taken only at edges where full is inactive; a character offered at a busy edge is dropped.
- R12: In bypass mode with `pre_sel_i`=0 and `rate_hi_i`=1, full stays inactive and every offered character is taken. In both bypass cases, empty is held asserted and half-full inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk_i | input | 1 | Reference (character-rate) clock |
| tx_clk_i | input | 1 | Host write clock, FIFO mode only |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bypass_ni | input | 1 | Strap: 0 selects bypass, 1 selects FIFO mode |
| ext_fifo_i | input | 1 | Strap: external-FIFO enable timing and flag polarity |
| pre_sel_i | input | 1 | Strap: prescale select, 1 enables bypass pacing |
| rate_hi_i | input | 1 | Strap: high-rate select, 0 enables bypass pacing |
| tx_en_i | input | 1 | Host write enable, polarity per `ext_fifo_i` |
| tx_data_i | input | 10 | Host character |
| full_o | output | 1 | Full flag, or pacing strobe in bypass mode |
| empty_o | output | 1 | Empty flag |
| half_o | output | 1 | Half-full flag, always active low |
| enc_data_o | output | 10 | Character to the encoder |
| enc_valid_o | output | 1 | `enc_data_o` holds a host character |
| fill_req_o | output | 1 | Encoder should insert a fill character |

## Verification
The assertions check several properties on every clock:

- occupancy never exceeds the depth;
- half-full accompanies full;
- an empty FIFO is followed by an idle encoder cycle;
- the pacing strobe alternates every reference edge, and nothing is taken on a busy edge;
- the unpaced bypass keeps its flags at fixed levels.

Some behaviours can only be shown by the bench scenarios. These are:

- the one-edge capture shift under the external-FIFO strap;
- in-order delivery across the clock crossing;
- dropping of writes made while full, judged from the data stream the encoder receives;
- the flag pin levels at reset and after draining;
- bypass operation with the write clock stopped.

// File: rtl/tx_host_pkg.sv
package tx_host_pkg;
  localparam int unsigned CHAR_W     = 10;
  localparam int unsigned FIFO_DEPTH = 16;

  typedef struct packed {
    logic full;
    logic empty;
    logic half;
  } flag_t;
endpackage

// File: rtl/tx_host_capture.sv
// Enable qualification; ext_i delays capture one edge and flips enable polarity.
module tx_host_capture (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic act_i,
  input  logic ext_i,
  input  logic en_pin_i,
  output logic wr_o
);
  logic en_act, en_q;

  assign en_act = ext_i ? en_pin_i : ~en_pin_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b0;
    else         en_q <= act_i & en_act;
  end

  assign wr_o = act_i & (ext_i ? en_q : en_act);
endmodule

// File: rtl/tx_host_fifo.sv
module tx_host_fifo #(
  parameter int unsigned DW    = 10,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned PW   = AW + 1
) (
  input  logic          wclk_i,
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rd_i,
  output logic [DW-1:0] rdata_o,
  output logic          full_o,
  output logic          empty_o,
  output logic [PW-1:0] level_o
);
  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wbin, wgray, wbin_nxt, rq1, rq2;
  logic [PW-1:0] rbin, rgray, rbin_nxt, wq1, wq2;
  logic          push, pop;

  // write domain
  assign push     = wr_i & ~full_o;
  assign wbin_nxt = wbin + {{AW{1'b0}}, push};
  assign full_o   = (wgray == {~rq2[PW-1:PW-2], rq2[PW-3:0]});
  assign level_o  = wbin - g2b(rq2);

  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wbin  <= '0;
      wgray <= '0;
      rq1   <= '0;
      rq2   <= '0;
    end else begin
      wbin  <= wbin_nxt;
      wgray <= wbin_nxt ^ (wbin_nxt >> 1);
      rq1   <= rgray;
      rq2   <= rq1;
    end
  end

  always_ff @(posedge wclk_i) begin
    if (push) mem[wbin[AW-1:0]] <= wdata_i;
  end

  // read domain
  assign pop      = rd_i & ~empty_o;
  assign rbin_nxt = rbin + {{AW{1'b0}}, pop};
  assign empty_o  = (rgray == wq2);
  assign rdata_o  = mem[rbin[AW-1:0]];

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rbin  <= '0;
      rgray <= '0;
      wq1   <= '0;
      wq2   <= '0;
    end else begin
      rbin  <= rbin_nxt;
      rgray <= rbin_nxt ^ (rbin_nxt >> 1);
      wq1   <= wgray;
      wq2   <= wq1;
    end
  end
endmodule

// File: rtl/tx_host_pacer.sv
// Half-rate busy strobe for paced bypass; starts not-busy after reset.
module tx_host_pacer (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic busy_o
);
  logic ph;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ph <= 1'b0;
    else         ph <= en_i ? ~ph : 1'b0;
  end

  assign busy_o = ph;
endmodule

// File: rtl/tx_host_if.sv
module tx_host_if
  import tx_host_pkg::*;
#(
  parameter int unsigned DW    = CHAR_W,
  parameter int unsigned DEPTH = FIFO_DEPTH,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned HALF = DEPTH / 2
) (
  input  logic          ref_clk_i,
  input  logic          tx_clk_i,
  input  logic          rst_ni,
  input  logic          bypass_ni,
  input  logic          ext_fifo_i,
  input  logic          pre_sel_i,
  input  logic          rate_hi_i,
  input  logic          tx_en_i,
  input  logic [DW-1:0] tx_data_i,
  output logic          full_o,
  output logic          empty_o,
  output logic          half_o,
  output logic [DW-1:0] enc_data_o,
  output logic          enc_valid_o,
  output logic          fill_req_o
);
  logic          byp, pace_en, busy;
  logic          wr_tx, wr_ref, byp_take;
  logic          f_full, f_empty;
  logic [DW-1:0] f_rdata;
  logic [AW:0]   fifo_level;
  flag_t         flg;

  assign byp     = ~bypass_ni;
  assign pace_en = byp & (pre_sel_i | ~rate_hi_i);

  tx_host_capture u_cap_tx (
    .clk_i   (tx_clk_i),
    .rst_ni  (rst_ni),
    .act_i   (bypass_ni),
    .ext_i   (ext_fifo_i),
    .en_pin_i(tx_en_i),
    .wr_o    (wr_tx)
  );

  tx_host_capture u_cap_ref (
    .clk_i   (ref_clk_i),
    .rst_ni  (rst_ni),
    .act_i   (byp),
    .ext_i   (ext_fifo_i),
    .en_pin_i(tx_en_i),
    .wr_o    (wr_ref)
  );

  tx_host_pacer u_pacer (
    .clk_i (ref_clk_i),
    .rst_ni(rst_ni),
    .en_i  (pace_en),
    .busy_o(busy)
  );

  tx_host_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .wclk_i (tx_clk_i),
    .rclk_i (ref_clk_i),
    .rst_ni (rst_ni),
    .wr_i   (wr_tx),
    .wdata_i(tx_data_i),
    .rd_i   (bypass_ni),
    .rdata_o(f_rdata),
    .full_o (f_full),
    .empty_o(f_empty),
    .level_o(fifo_level)
  );

  assign byp_take = wr_ref & ~busy;

  always_ff @(posedge ref_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      enc_valid_o <= 1'b0;
      enc_data_o  <= '0;
    end else if (byp) begin
      enc_valid_o <= byp_take;
      if (byp_take) enc_data_o <= tx_data_i;
    end else begin
      enc_valid_o <= ~f_empty;
      if (!f_empty) enc_data_o <= f_rdata;
    end
  end

  assign fill_req_o = ~enc_valid_o;

  // logical (active-high) flags, then strap-dependent pin polarity
  always_comb begin
    if (byp) begin
      flg.full  = busy;
      flg.empty = 1'b1;
      flg.half  = 1'b0;
    end else begin
      flg.full  = f_full;
      flg.empty = f_empty;
      flg.half  = (fifo_level >= (AW+1)'(HALF));
    end
  end

  assign full_o  = ext_fifo_i ? flg.full  : ~flg.full;
  assign empty_o = ext_fifo_i ? flg.empty : ~flg.empty;
  assign half_o  = ~flg.half;
endmodule

// File: rtl/tx_host_if_chk.sv
module tx_host_if_chk #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input logic        ref_clk_i,
  input logic        tx_clk_i,
  input logic        rst_ni,
  input logic        bypass_ni,
  input logic        ext_fifo_i,
  input logic        pre_sel_i,
  input logic        rate_hi_i,
  input logic        full_o,
  input logic        empty_o,
  input logic        half_o,
  input logic        enc_valid_o,
  input logic [AW:0] fifo_level_i
);
  logic full_l, empty_l, half_l, pace;

  assign full_l  = ext_fifo_i ? full_o : ~full_o;
  assign empty_l = ext_fifo_i ? empty_o : ~empty_o;
  assign half_l  = ~half_o;
  assign pace    = ~bypass_ni & (pre_sel_i | ~rate_hi_i);

  assert_no_overflow_R7: assert property (@(posedge tx_clk_i) disable iff (!rst_ni)
    bypass_ni |-> (fifo_level_i <= (AW+1)'(DEPTH)));

  assert_half_on_full_R8: assert property (@(posedge tx_clk_i) disable iff (!rst_ni)
    (bypass_ni && full_l) |-> half_l);

  assert_empty_idle_R9: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    (bypass_ni && empty_l) |=> !enc_valid_o);

  assert_pace_toggle_R11: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    pace |=> (full_o != $past(full_o)));

  assert_busy_no_take_R11: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    (pace && full_l) |=> !enc_valid_o);

  assert_nopace_flags_R12: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    (!bypass_ni && !pace) |-> (!full_l && empty_l && !half_l));
endmodule

bind tx_host_if tx_host_if_chk #(.DEPTH(DEPTH)) u_chk (
  .ref_clk_i   (ref_clk_i),
  .tx_clk_i    (tx_clk_i),
  .rst_ni      (rst_ni),
  .bypass_ni   (bypass_ni),
  .ext_fifo_i  (ext_fifo_i),
  .pre_sel_i   (pre_sel_i),
  .rate_hi_i   (rate_hi_i),
  .full_o      (full_o),
  .empty_o     (empty_o),
  .half_o      (half_o),
  .enc_valid_o (enc_valid_o),
  .fifo_level_i(fifo_level)
);

// File: tb/sim_tx_host_if.sv
`timescale 1ns/1ps
module sim_tx_host_if;
  logic       ref_clk = 0, tx_clk = 0, tx_run = 1;
  logic       rst_ni = 0;
  logic       bypass_ni = 1, ext_fifo = 0, pre_sel = 0, rate_hi = 1;
  logic       tx_en = 1;
  logic [9:0] tx_data = '0;
  logic       full_o, empty_o, half_o, enc_valid_o, fill_req_o;
  logic [9:0] enc_data_o;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [9:0] sb_q[$];
  logic [9:0] next_d = 10'h001;
  int refused, toggle_bad, full_hits;
  bit saw_full, saw_half;

  always #5 ref_clk = ~ref_clk;
  always #2 if (tx_run) tx_clk = ~tx_clk;

  tx_host_if u0 (
    .ref_clk_i(ref_clk), .tx_clk_i(tx_clk), .rst_ni(rst_ni),
    .bypass_ni(bypass_ni), .ext_fifo_i(ext_fifo), .pre_sel_i(pre_sel), .rate_hi_i(rate_hi),
    .tx_en_i(tx_en), .tx_data_i(tx_data),
    .full_o(full_o), .empty_o(empty_o), .half_o(half_o),
    .enc_data_o(enc_data_o), .enc_valid_o(enc_valid_o), .fill_req_o(fill_req_o)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on every character handed to the encoder
  always @(negedge ref_clk) begin
    if (rst_ni && !done) begin
      chk(fill_req_o == !enc_valid_o, "R9", "fill_req vs valid", fill_req_o, !enc_valid_o);
      if (enc_valid_o) begin
        if (sb_q.size() == 0) chk(0, "R6", "unexpected character", enc_data_o, -1);
        else begin
          logic [9:0] e;
          e = sb_q.pop_front();
          chk(enc_data_o == e, "R6", "character order/value", enc_data_o, e);
        end
      end
    end
  end

  task automatic do_reset(input bit byp_n, input bit ext, input bit pre, input bit rate);
    @(negedge ref_clk);
    rst_ni = 0;
    bypass_ni = byp_n; ext_fifo = ext; pre_sel = pre; rate_hi = rate;
    tx_en = !ext;
    sb_q.delete();
    repeat (3) @(negedge ref_clk);
    rst_ni = 1;
    #1;
  endtask

  // driver: offers n characters (one every gap cycles), pushes the ones the spec says are taken
  task automatic drive(input int n, input int gap, input bit on_ref);
    bit pend = 0, fl, offer, prev_full;
    refused = 0; toggle_bad = 0; full_hits = 0; saw_full = 0; saw_half = 0;
    prev_full = full_o;
    for (int c = 0; c <= n; c++) begin
      if (on_ref) @(negedge ref_clk); else @(negedge tx_clk);
      fl = ext_fifo ? full_o : !full_o;
      if (fl) begin saw_full = 1; full_hits++; end
      if (!half_o) saw_half = 1;
      if (on_ref && c > 0 && full_o == prev_full) toggle_bad++;
      prev_full = full_o;
      offer = (c < n) && (c % gap == 0);
      tx_data = next_d;
      if (ext_fifo) begin
        if (pend) begin
          if (!fl) sb_q.push_back(next_d); else refused++;
        end
        pend = offer;
        tx_en = offer;
      end else begin
        tx_en = !offer;
        if (offer) begin
          if (!fl) sb_q.push_back(next_d); else refused++;
        end
      end
      next_d = next_d + 10'd1;
    end
    if (on_ref) @(negedge ref_clk); else @(negedge tx_clk);
    tx_en = !ext_fifo;
  endtask

  initial begin
    repeat (200000) @(posedge ref_clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // FIFO mode, flags active low
    do_reset(1, 0, 0, 1);
    chk(full_o == 1,   "R1", "reset full_o (R2 low-active)", full_o, 1);
    chk(empty_o == 0,  "R1", "reset empty_o (R2 low-active)", empty_o, 0);
    chk(half_o == 1,   "R1", "reset half_o", half_o, 1);
    chk(enc_valid_o == 0 && fill_req_o == 1, "R1", "reset valid/fill", enc_valid_o, 0);
    drive(40, 1, 0);                       // R4: same-edge capture, fills the FIFO
    chk(saw_full,      "R7", "full reached (pin low)", saw_full, 1);
    chk(refused > 0,   "R7", "writes refused while full", refused, 1);
    chk(saw_half,      "R8", "half-full reached", saw_half, 1);
    repeat (80) @(negedge ref_clk);
    chk(sb_q.size() == 0, "R6", "all accepted characters delivered", sb_q.size(), 0);
    chk(empty_o == 0 && full_o == 1 && half_o == 1, "R2", "drained pin levels", {empty_o, full_o, half_o}, 3'b011);
    chk(fill_req_o == 1, "R9", "fill request when empty", fill_req_o, 1);

    // FIFO mode, external-FIFO strap
    do_reset(1, 1, 0, 1);
    chk(full_o == 0 && empty_o == 1 && half_o == 1, "R3", "reset pins with strap", {full_o, empty_o, half_o}, 3'b011);
    chk(enc_valid_o == 0, "R1", "reset valid", enc_valid_o, 0);
    drive(40, 1, 0);                       // R5: one-edge-late capture
    chk(saw_full,      "R3", "full reached (pin high)", saw_full, 1);
    chk(saw_half,      "R3", "half-full low with strap", saw_half, 1);
    chk(refused > 0,   "R7", "writes refused while full", refused, 1);
    repeat (80) @(negedge ref_clk);
    chk(sb_q.size() == 0, "R5", "delivery with delayed capture", sb_q.size(), 0);
    drive(12, 3, 0);                       // sparse pattern, no overflow
    chk(refused == 0,  "R5", "sparse writes all taken", refused, 0);
    repeat (40) @(negedge ref_clk);
    chk(sb_q.size() == 0, "R6", "sparse delivery", sb_q.size(), 0);
    chk(empty_o == 1 && full_o == 0, "R3", "drained pins with strap", {empty_o, full_o}, 2'b10);

    // bypass, paced by prescale select, tx clock stopped
    tx_run = 0;
    do_reset(0, 0, 1, 1);
    chk(full_o == 1,   "R1", "bypass reset full inactive", full_o, 1);
    drive(20, 1, 1);
    chk(toggle_bad == 0, "R11", "full toggles each ref edge", toggle_bad, 0);
    chk(refused > 0,   "R11", "offers dropped on busy edges", refused, 1);
    repeat (4) @(negedge ref_clk);
    chk(sb_q.size() == 0, "R10", "bypass delivery, tx clock stopped", sb_q.size(), 0);
    chk(empty_o == 0 && half_o == 1, "R12", "bypass empty/half levels", {empty_o, half_o}, 2'b01);

    // bypass, unpaced, strap high
    do_reset(0, 1, 0, 1);
    drive(16, 1, 1);
    chk(full_hits == 0, "R12", "full stays inactive", full_hits, 0);
    chk(refused == 0,  "R12", "every offer taken", refused, 0);
    repeat (4) @(negedge ref_clk);
    chk(sb_q.size() == 0, "R10", "unpaced bypass delivery", sb_q.size(), 0);
    chk(empty_o == 1 && half_o == 1, "R12", "bypass flags with strap", {empty_o, half_o}, 2'b11);

    // bypass, paced by low rate select
    do_reset(0, 1, 0, 0);
    chk(full_o == 0,   "R11", "reset strobe inactive (strap high)", full_o, 0);
    drive(10, 1, 1);
    chk(toggle_bad == 0, "R11", "rate-select pacing toggles", toggle_bad, 0);
    repeat (4) @(negedge ref_clk);
    chk(sb_q.size() == 0, "R11", "paced delivery", sb_q.size(), 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule